// File: doc/BRIEF.md
# Four-Entry Page Translation Cache with Joint-TLB Refill

This block is a small fully associative translation cache placed in front of a larger joint TLB. It serves one access stream, either instruction fetches or data accesses, with single-cycle virtual-to-physical translation. Two instances can therefore translate in parallel without contending for the joint TLB. Each of the four entries maps one fixed 4 KB page. The low 12 address bits bypass the lookup, and the upper bits are compared against all four entries at once.

On a hit, the physical address and a per-entry valid bit come back in the same cycle. On a miss, the lookup port stalls. The block sends the virtual page number to the joint TLB over a valid/ready request and waits for the response. It writes the returned frame into a victim entry and then completes the stalled lookup. Invalid entries are filled first. Once all four entries are valid, a parameter selects the replacement policy: a pair-based pseudo-LRU tree (data variant) or true LRU by age ranking (instruction variant). A flush input empties the cache in one cycle. Software cannot see the entries.

Top module: `micro_tlb`

## Requirements
- R1: After reset, `lk_rdy_o` is 1, `mreq_valid_o` and `lk_hit_o` are 0, and every lookup misses.
- R2: A lookup (`lk_req_i`=1 while `lk_rdy_o`=1) of a cached page raises `lk_hit_o` in the same cycle. In that cycle `lk_pv_o` gives the valid bit that was stored with the entry.
- R3: On a hit, `lk_pa_o` equals the cached frame number concatenated with bits 11:0 of `lk_va_i`, which are passed through untranslated.
- R4: On a miss, `lk_hit_o` stays 0. From the next cycle `mreq_valid_o` is 1 with `mreq_vpn_o` equal to `lk_va_i[VA_W-1:12]`, and both are held until `mreq_ready_i` is sampled high. `lk_rdy_o` is 0 from the cycle after the miss until the refill ends.
- R5: After the handshake, the cycle in which `mrsp_valid_i` is sampled high writes `mrsp_pfn_i` and `mrsp_pv_i` into an entry. In the next cycle the held lookup hits with the returned frame.
- R6: A refill writes the lowest-numbered invalid entry if one exists. No valid entry is replaced while any entry is invalid.
- R7: With `REPL_MODE`=0, the victim is chosen from the pair least recently used (entries 0–1 or 2–3), and within that pair it is the less recently used entry. Hits and refills both count as uses.
- R8: With `REPL_MODE`=1, the victim is the entry least recently used among all four. Hits and refills both count as uses.
- R9: A cycle with `flush_i`=1 invalidates all entries, resets the replacement state, and abandons any refill in progress. `lk_rdy_o` is 1 in the next cycle.
- R10: `mrsp_valid_i` has no effect unless a refill is waiting for its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_req_i | input | 1 | Lookup request, held until hit |
| lk_va_i | input | VA_W | Virtual address to translate |
| lk_rdy_o | output | 1 | Lookup port not stalled |
| lk_hit_o | output | 1 | Translation valid this cycle |
| lk_pa_o | output | PA_W | Translated physical address |
| lk_pv_o | output | 1 | Page valid bit of the hit entry |
| mreq_valid_o | output | 1 | Refill request to joint TLB |
| mreq_ready_i | input | 1 | Joint TLB accepts request |
| mreq_vpn_o | output | VA_W-12 | Virtual page number requested |
| mrsp_valid_i | input | 1 | Refill response strobe |
| mrsp_pfn_i | input | PA_W-12 | Returned physical frame number |
| mrsp_pv_i | input | 1 | Returned page valid bit |

## Verification
Both policy variants are driven in turn. Each gets random lookups over a pool of six pages, which is larger than the four entries, so evictions happen often. The bench model's victim choice then decides every later hit or miss, and a wrong victim shows up as a mismatch. A directed sequence fills four pages after a flush and then reuses them. This separates invalid-first filling from policy-based eviction. A second directed sequence touches entries in an order for which the tree policy and true LRU evict different entries. Further directed cases send a flush during a pending refill and a response strobe outside a refill. Random ready back-pressure and response delays test whether the request is held steady and the stall is released at the right time.

// File: rtl/utlb_pkg.sv
`timescale 1ns/1ps
package utlb_pkg;
    localparam int PAGE_BITS = 12;
    localparam int ENTRIES   = 4;
    localparam int IDX_W     = $clog2(ENTRIES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } fill_st_e;
endpackage

// File: rtl/utlb_cam.sv
`timescale 1ns/1ps
module utlb_cam
    import utlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [VPN_W-1:0] look_vpn_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] hit_idx_o,
    output logic [PFN_W-1:0] hit_pfn_o,
    output logic             hit_pv_o,
    output logic [ENTRIES-1:0] valid_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [VPN_W-1:0] wr_vpn_i,
    input  logic [PFN_W-1:0] wr_pfn_i,
    input  logic             wr_pv_i
);
    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [ENTRIES-1:0]            pv;
    } cam_t;

    cam_t cam_d, cam_q;
    logic [ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = cam_q.valid[g] && (cam_q.vpn[g] == look_vpn_i);
    end

    always_comb begin
        hit_idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) hit_idx_o = IDX_W'(i);
        end
    end

    assign hit_o     = |match_vec;
    assign hit_pfn_o = cam_q.pfn[hit_idx_o];
    assign hit_pv_o  = cam_q.pv[hit_idx_o];
    assign valid_o   = cam_q.valid;

    always_comb begin
        cam_d = cam_q;
        if (flush_i) begin
            cam_d.valid = '0;
        end else if (wr_en_i) begin
            cam_d.valid[wr_idx_i] = 1'b1;
            cam_d.vpn[wr_idx_i]   = wr_vpn_i;
            cam_d.pfn[wr_idx_i]   = wr_pfn_i;
            cam_d.pv[wr_idx_i]    = wr_pv_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cam_q <= '0;
        else        cam_q <= cam_d;
    end

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_o == '0));
endmodule

// File: rtl/utlb_repl.sv
`timescale 1ns/1ps
module utlb_repl
    import utlb_pkg::*;
#(
    parameter int REPL_MODE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             touch_i,
    input  logic [IDX_W-1:0] touch_idx_i,
    output logic [IDX_W-1:0] victim_o
);
    if (REPL_MODE == 0) begin : g_tree
        // bit0: stale pair; bit1: stale entry in pair 0; bit2: stale entry in pair 1
        logic [2:0] tree_d, tree_q;

        always_comb begin
            tree_d = tree_q;
            if (flush_i) begin
                tree_d = '0;
            end else if (touch_i) begin
                tree_d[0] = ~touch_idx_i[1];
                if (touch_idx_i[1]) tree_d[2] = ~touch_idx_i[0];
                else                tree_d[1] = ~touch_idx_i[0];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) tree_q <= '0;
            else        tree_q <= tree_d;
        end

        assign victim_o = {tree_q[0], tree_q[0] ? tree_q[2] : tree_q[1]};

        // R7
        tree_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (touch_i && !flush_i) |=> (victim_o[1] != $past(touch_idx_i[1])));
    end else begin : g_age
        logic [ENTRIES-1:0][IDX_W-1:0] age_d, age_q, age_init;

        always_comb begin
            for (int i = 0; i < ENTRIES; i++) age_init[i] = IDX_W'(i);
        end

        always_comb begin
            age_d = age_q;
            if (flush_i) begin
                age_d = age_init;
            end else if (touch_i) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (age_q[i] < age_q[touch_idx_i]) age_d[i] = age_q[i] + 1'b1;
                end
                age_d[touch_idx_i] = '0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) age_q <= age_init;
            else        age_q <= age_d;
        end

        always_comb begin
            victim_o = '0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_o = IDX_W'(i);
            end
        end

        // R8
        age_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q[0] != age_q[1]) && (age_q[0] != age_q[2]) && (age_q[0] != age_q[3]) &&
            (age_q[1] != age_q[2]) && (age_q[1] != age_q[3]) && (age_q[2] != age_q[3]));

        // R8
        age_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (touch_i && !flush_i) |=> (age_q[$past(touch_idx_i)] == '0));
    end
endmodule

// File: rtl/micro_tlb.sv
`timescale 1ns/1ps
module micro_tlb
    import utlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int REPL_MODE = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic                      lk_req_i,
    input  logic [VA_W-1:0]           lk_va_i,
    output logic                      lk_rdy_o,
    output logic                      lk_hit_o,
    output logic [PA_W-1:0]           lk_pa_o,
    output logic                      lk_pv_o,
    output logic                      mreq_valid_o,
    input  logic                      mreq_ready_i,
    output logic [VA_W-PAGE_BITS-1:0] mreq_vpn_o,
    input  logic                      mrsp_valid_i,
    input  logic [PA_W-PAGE_BITS-1:0] mrsp_pfn_i,
    input  logic                      mrsp_pv_i
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PFN_W = PA_W - PAGE_BITS;

    typedef struct packed {
        fill_st_e         st;
        logic [VPN_W-1:0] vpn;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [VPN_W-1:0]   look_vpn;
    logic               cam_hit;
    logic [IDX_W-1:0]   cam_idx;
    logic [PFN_W-1:0]   cam_pfn;
    logic               cam_pv;
    logic [ENTRIES-1:0] cam_valid;
    logic [IDX_W-1:0]   repl_victim;
    logic [IDX_W-1:0]   fill_idx;
    logic               wr_en;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;
    logic               idle;

    assign look_vpn = lk_va_i[VA_W-1:PAGE_BITS];
    assign idle     = (ctl_q.st == ST_IDLE);

    utlb_cam #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .look_vpn_i (look_vpn),
        .hit_o      (cam_hit),
        .hit_idx_o  (cam_idx),
        .hit_pfn_o  (cam_pfn),
        .hit_pv_o   (cam_pv),
        .valid_o    (cam_valid),
        .wr_en_i    (wr_en),
        .wr_idx_i   (fill_idx),
        .wr_vpn_i   (ctl_q.vpn),
        .wr_pfn_i   (mrsp_pfn_i),
        .wr_pv_i    (mrsp_pv_i)
    );

    utlb_repl #(.REPL_MODE(REPL_MODE)) u_repl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .touch_i     (touch_en),
        .touch_idx_i (touch_idx),
        .victim_o    (repl_victim)
    );

    // free slots take precedence over the policy victim
    always_comb begin
        fill_idx = repl_victim;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!cam_valid[i]) fill_idx = IDX_W'(i);
        end
    end

    always_comb begin
        ctl_d     = ctl_q;
        wr_en     = 1'b0;
        touch_en  = 1'b0;
        touch_idx = cam_idx;
        if (flush_i) begin
            ctl_d.st = ST_IDLE;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (lk_req_i) begin
                        if (cam_hit) begin
                            touch_en = 1'b1;
                        end else begin
                            ctl_d.st  = ST_REQ;
                            ctl_d.vpn = look_vpn;
                        end
                    end
                end
                ST_REQ: begin
                    if (mreq_ready_i) ctl_d.st = ST_WAIT;
                end
                ST_WAIT: begin
                    if (mrsp_valid_i) begin
                        wr_en     = 1'b1;
                        touch_en  = 1'b1;
                        touch_idx = fill_idx;
                        ctl_d.st  = ST_IDLE;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, vpn: '0};
        else        ctl_q <= ctl_d;
    end

    assign lk_rdy_o     = idle;
    assign lk_hit_o     = lk_req_i && idle && cam_hit;
    assign lk_pa_o      = {cam_pfn, lk_va_i[PAGE_BITS-1:0]};
    assign lk_pv_o      = cam_pv;
    assign mreq_valid_o = (ctl_q.st == ST_REQ);
    assign mreq_vpn_o   = ctl_q.vpn;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
        (mreq_valid_o && !mreq_ready_i) |=> (mreq_valid_o && $stable(mreq_vpn_o)));

    // R4
    req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid_o |-> !lk_rdy_o);

    // R2
    hit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> lk_rdy_o);

    // R9
    flush_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (lk_rdy_o && !mreq_valid_o));

    // R4
    miss_launch_chk: assert property (@(posedge clk) disable iff (!rst_n || flush_i)
        (lk_req_i && lk_rdy_o && !lk_hit_o) |=> (mreq_valid_o && mreq_vpn_o == $past(lk_va_i[VA_W-1:PAGE_BITS])));
endmodule

// File: tb/micro_tlb_tb.sv
`timescale 1ns/1ps
module micro_tlb_tb;
    localparam int VA_W = 32;
    localparam int PA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic req = 1'b0;
    logic [VA_W-1:0] va = '0;
    logic mready = 1'b0;
    logic rspv = 1'b0;
    logic [19:0] rsp_pfn = '0;
    logic rsp_pv = 1'b0;
    int   mode = 0;

    logic rdy0, hit0, pv0, mv0, rdy1, hit1, pv1, mv1;
    logic [PA_W-1:0] pa0, pa1;
    logic [19:0] mvpn0, mvpn1;

    always #2.5 clk = ~clk;

    micro_tlb #(.VA_W(VA_W), .PA_W(PA_W), .REPL_MODE(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .lk_req_i(req && mode == 0),
        .lk_va_i(va), .lk_rdy_o(rdy0), .lk_hit_o(hit0), .lk_pa_o(pa0), .lk_pv_o(pv0),
        .mreq_valid_o(mv0), .mreq_ready_i(mready), .mreq_vpn_o(mvpn0),
        .mrsp_valid_i(rspv), .mrsp_pfn_i(rsp_pfn), .mrsp_pv_i(rsp_pv));

    micro_tlb #(.VA_W(VA_W), .PA_W(PA_W), .REPL_MODE(1)) u_dut_lru (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .lk_req_i(req && mode == 1),
        .lk_va_i(va), .lk_rdy_o(rdy1), .lk_hit_o(hit1), .lk_pa_o(pa1), .lk_pv_o(pv1),
        .mreq_valid_o(mv1), .mreq_ready_i(mready), .mreq_vpn_o(mvpn1),
        .mrsp_valid_i(rspv), .mrsp_pfn_i(rsp_pfn), .mrsp_pv_i(rsp_pv));

    wire o_rdy = (mode == 0) ? rdy0 : rdy1;
    wire o_hit = (mode == 0) ? hit0 : hit1;
    wire o_pv  = (mode == 0) ? pv0 : pv1;
    wire o_mv  = (mode == 0) ? mv0 : mv1;
    wire [PA_W-1:0] o_pa  = (mode == 0) ? pa0 : pa1;
    wire [19:0]     o_mvpn = (mode == 0) ? mvpn0 : mvpn1;

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s mode=%0d actual=%h expected=%h", rq, mode, act, exp);
        end
    endtask

    // reference model
    bit          m_v[4];
    logic [19:0] m_vpn[4];
    logic [19:0] m_pfn[4];
    bit          m_pv[4];
    logic [2:0]  m_tree;
    int          m_age[4];

    function automatic logic [19:0] pfn_of(input logic [19:0] vpn);
        return vpn ^ 20'h5A5A5;
    endfunction

    function automatic bit pv_of(input logic [19:0] vpn);
        return ^vpn;
    endfunction

    function automatic int m_find(input logic [19:0] vpn);
        for (int i = 0; i < 4; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        for (int i = 0; i < 4; i++) if (!m_v[i]) return i;
        if (mode == 0) return m_tree[0] ? (2 + int'(m_tree[2])) : int'(m_tree[1]);
        for (int i = 0; i < 4; i++) if (m_age[i] == 3) return i;
        return 0;
    endfunction

    task automatic m_touch(input int e);
        int ae;
        m_tree[0] = ~e[1];
        if (e[1]) m_tree[2] = ~e[0];
        else      m_tree[1] = ~e[0];
        ae = m_age[e];
        for (int i = 0; i < 4; i++) if (m_age[i] < ae) m_age[i]++;
        m_age[e] = 0;
    endtask

    task automatic m_reset();
        for (int i = 0; i < 4; i++) begin
            m_v[i] = 0;
            m_age[i] = i;
        end
        m_tree = '0;
    endtask

    function automatic string pol_tag();
        return (mode == 0) ? "R7" : "R8";
    endfunction

    task automatic access(input logic [19:0] vpn, input logic [11:0] ofs, input string tag);
        int e;
        int v;
        int tries;
        int d;
        bit rd;
        e = m_find(vpn);
        @(negedge clk);
        req = 1'b1;
        va  = {vpn, ofs};
        #0.5;
        if (e >= 0) begin
            chk(o_hit == 1'b1, tag, 64'(o_hit), 64'd1);
            chk(o_pa == {m_pfn[e], ofs}, "R3", 64'(o_pa), 64'({m_pfn[e], ofs}));
            chk(o_pv == m_pv[e], "R2", 64'(o_pv), 64'(m_pv[e]));
            @(posedge clk);
            m_touch(e);
        end else begin
            chk(o_hit == 1'b0, tag, 64'(o_hit), 64'd0);
            @(posedge clk);
            tries = 0;
            forever begin
                @(negedge clk);
                #0.5;
                chk(o_mv == 1'b1 && o_mvpn == vpn, "R4", 64'({o_mv, o_mvpn}), 64'({1'b1, vpn}));
                chk(o_rdy == 1'b0, "R4", 64'(o_rdy), 64'd0);
                rd = (tries >= 2) || ($urandom % 2 == 0);
                mready = rd;
                tries++;
                @(posedge clk);
                if (rd) break;
            end
            @(negedge clk);
            mready = 1'b0;
            #0.5;
            d = $urandom % 3;
            for (int i = 0; i < d; i++) begin
                chk(o_mv == 1'b0 && o_rdy == 1'b0, "R4", 64'({o_mv, o_rdy}), 64'd0);
                @(negedge clk);
                #0.5;
            end
            rspv = 1'b1;
            rsp_pfn = pfn_of(vpn);
            rsp_pv = pv_of(vpn);
            @(posedge clk);
            @(negedge clk);
            rspv = 1'b0;
            #0.5;
            v = m_victim();
            m_v[v] = 1;
            m_vpn[v] = vpn;
            m_pfn[v] = pfn_of(vpn);
            m_pv[v] = pv_of(vpn);
            m_touch(v);
            chk(o_hit == 1'b1 && o_rdy == 1'b1, "R5", 64'({o_hit, o_rdy}), 64'd3);
            chk(o_pa == {pfn_of(vpn), ofs}, "R5", 64'(o_pa), 64'({pfn_of(vpn), ofs}));
            chk(o_pv == pv_of(vpn), "R5", 64'(o_pv), 64'(pv_of(vpn)));
            @(posedge clk);
        end
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        m_reset();
    endtask

    function automatic logic [19:0] pool(input int k);
        return 20'h10000 + 20'(k * 20'h111);
    endfunction

    task automatic run_mode(input int md);
        mode = md;
        m_reset();
        do_flush();
        #0.5;
        // R1: idle outputs after reset/flush
        chk(o_rdy == 1'b1 && o_mv == 1'b0 && o_hit == 1'b0, "R1", 64'({o_rdy, o_mv, o_hit}), 64'd4);
        access(pool(0), 12'h000, "R1");
        // R6: fill after flush, no eviction while free entries remain
        for (int k = 1; k < 4; k++) access(pool(k), 12'(k * 12'h123), "R6");
        for (int k = 0; k < 4; k++) access(pool(k), 12'hFFF, "R6");
        // policy-discriminating sequence
        do_flush();
        for (int k = 0; k < 4; k++) access(pool(k), 12'h010, "R6");
        access(pool(0), 12'h020, pol_tag());
        access(pool(4), 12'h030, pol_tag());
        access(pool(1), 12'h040, pol_tag());
        access(pool(2), 12'h050, pol_tag());
        // random traffic over six pages
        for (int n = 0; n < 250; n++) begin
            access(pool($urandom % 6), 12'($urandom), pol_tag());
        end
        // R9: flush abandons a refill in progress; R10: late response ignored
        @(negedge clk);
        req = 1'b1;
        va = {pool(5) ^ 20'h00F00, 12'h0};
        @(posedge clk);
        @(negedge clk);
        mready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mready = 1'b0;
        req = 1'b0;
        flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        m_reset();
        #0.5;
        chk(o_rdy == 1'b1 && o_mv == 1'b0, "R9", 64'({o_rdy, o_mv}), 64'd2);
        @(negedge clk);
        rspv = 1'b1;
        rsp_pfn = 20'hABCDE;
        rsp_pv = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rspv = 1'b0;
        access(pool(5) ^ 20'h00F00, 12'h004, "R10");
        access(pool(0), 12'h008, "R9");
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        mode = 0;
        chk(rdy0 && !mv0 && !hit0, "R1", 64'({rdy0, mv0, hit0}), 64'd4);
        mode = 1;
        chk(rdy1 && !mv1 && !hit1, "R1", 64'({rdy1, mv1, hit1}), 64'd4);
        run_mode(0);
        run_mode(1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule